// File: doc/BRIEF.md
# Multimode Timer with PWM and Capture

This block is a single general-purpose timer channel built around one counter that serves three modes. In PWM mode the counter runs on the system clock and produces a pulse-width-modulated output whose period and high time come from two configuration inputs. In event mode the counter advances on rising edges of an external pin and raises an interrupt every time a programmed number of events has been seen. In capture mode the counter times an external input in system clock cycles and latches the high time and the rise-to-rise time of each pulse, which lets software measure the bit time of an incoming serial stream and derive a baud rate from it.

The external pin is always brought into the clock domain through a two-flop synchroniser followed by an edge detector, so it may be fully asynchronous. Configuration (mode, period, width) is meant to be changed while the channel is disabled; dropping the enable clears the counter, the capture sequencing and the overflow flag.

Top module: `mm_timer`

## Requirements
- R1: After reset, countOut, capWidth and capPeriod are zero and pwmOut, irq and overflow are low.
- R2: While enable is low, or while mode is 3 (reserved), the counter is held at zero, pwmOut and irq stay low and overflow is cleared one cycle after enable falls.
- R3: In PWM mode (mode 0) the counter runs 0,1,...,periodIn-1 and then restarts at 0; pwmOut is high exactly while the count is below widthIn. A periodIn of 0 gives a period of 2^CW cycles.
- R4: In PWM mode a widthIn of 0 keeps pwmOut low, and a widthIn at or above a non-zero periodIn keeps pwmOut high.
- R5: In PWM mode irq is a one-cycle pulse in the first cycle of every new period (the cycle in which the count is 0 after a restart), not in the first cycle after enabling.
- R6: In event mode (mode 1) each synchronised rising edge of extIn advances the count by one; the edge that arrives with the count at periodIn-1 returns it to 0 and raises irq for one cycle, in the same cycle the count shows 0.
- R7: In capture mode (mode 2) the number of clock cycles extIn was high is latched into capWidth when its falling edge is detected.
- R8: In capture mode the number of cycles between two successive rising edges is latched into capPeriod at the second edge, with irq high in the same cycle the new value appears; the first rising edge after enabling only starts timing.
- R9: In capture mode, once timing has started, a counter step past all ones wraps the count and sets overflow, which stays set until enable is dropped.
- R10: pwmOut is low in every mode other than PWM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; low clears counter and sequencing |
| mode | input | 2 | 0 PWM, 1 event count, 2 capture, 3 reserved (idle) |
| periodIn | input | CW | PWM period / event terminal count |
| widthIn | input | CW | PWM high time |
| extIn | input | 1 | Asynchronous external pin (events or measured signal) |
| pwmOut | output | 1 | PWM waveform |
| irq | output | 1 | One-cycle interrupt pulse |
| overflow | output | 1 | Sticky capture overflow flag |
| countOut | output | CW | Current counter value |
| capWidth | output | CW | Last captured high time |
| capPeriod | output | CW | Last captured rise-to-rise time |

## Verification
The bench aims at the PWM limits: a zero width, a width beyond the period and a zero period that must stretch to the full counter range; a comparator off by one or a missing special case would show a glitch pulse or a wrong period. In capture mode it checks that the first edge after enabling produces no interrupt and that widths and periods of uneven pulses are exact in cycles, which an arming error or a latch taken one cycle late would break by one count or by a spurious interrupt. Event-mode wrap at the terminal count, overflow on a long high pulse and its clearing on disable are each checked against the point at which a wrong design would miscount or keep the flag stale.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  typedef enum logic [1:0] {
    MODE_PWM  = 2'b00,
    MODE_EVT  = 2'b01,
    MODE_CAP  = 2'b10,
    MODE_IDLE = 2'b11
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;   // count <= 0
    logic set1;  // count <= 1 (capture restart)
    logic inc;   // count <= count + 1
    logic capW;  // capWidth <= count
    logic capP;  // capPeriod <= count
  } ctrlStrobe_t;

endpackage

// File: rtl/mmt_edge_sync.sv
module mmt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[STAGES-1];
  end

  assign rise = syncQ[STAGES-1] & ~prevQ;
  assign fall = ~syncQ[STAGES-1] & prevQ;
endmodule

// File: rtl/mmt_datapath.sv
module mmt_datapath
  import mmt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [CW-1:0] periodIn,
  input  logic [CW-1:0] widthIn,
  output logic [CW-1:0] count,
  output logic [CW-1:0] capWidth,
  output logic [CW-1:0] capPeriod,
  output logic          terminal,
  output logic          atMax,
  output logic          belowWidth
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] lastCount;

  assign lastCount  = periodIn - ONE;  // period 0 -> all ones
  assign terminal   = (count >= lastCount);
  assign atMax      = &count;
  assign belowWidth = (count < widthIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (strobe.clr)  count <= '0;
    else if (strobe.set1) count <= ONE;
    else if (strobe.inc)  count <= count + ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capWidth  <= '0;
      capPeriod <= '0;
    end else begin
      if (strobe.capW) capWidth  <= count;
      if (strobe.capP) capPeriod <= count;
    end
  end
endmodule

// File: rtl/mmt_ctrl.sv
module mmt_ctrl
  import mmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic [1:0]  mode,
  input  logic        rise,
  input  logic        fall,
  input  logic        terminal,
  input  logic        atMax,
  output ctrlStrobe_t strobe,
  output logic        pwmEn,
  output logic        irq,
  output logic        overflow
);
  mode_e modeE;
  logic  startedQ;
  logic  haveWidthQ;

  assign modeE = mode_e'(mode);
  assign pwmEn = enable && (modeE == MODE_PWM);

  always_comb begin
    strobe = '0;
    if (!enable) begin
      strobe.clr = 1'b1;
    end else begin
      unique case (modeE)
        MODE_PWM: begin
          if (terminal) strobe.clr = 1'b1;
          else          strobe.inc = 1'b1;
        end
        MODE_EVT: begin
          if (rise) begin
            if (terminal) strobe.clr = 1'b1;
            else          strobe.inc = 1'b1;
          end
        end
        MODE_CAP: begin
          if (rise) begin
            strobe.set1 = 1'b1;
            strobe.capP = startedQ && haveWidthQ;
          end else if (startedQ) begin
            strobe.inc  = 1'b1;
            strobe.capW = fall;
          end
        end
        default: strobe.clr = 1'b1;
      endcase
    end
  end

  // capture sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startedQ   <= 1'b0;
      haveWidthQ <= 1'b0;
    end else if (!enable || modeE != MODE_CAP) begin
      startedQ   <= 1'b0;
      haveWidthQ <= 1'b0;
    end else if (rise) begin
      startedQ   <= 1'b1;
      haveWidthQ <= 1'b0;
    end else if (fall && startedQ) begin
      haveWidthQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq      <= 1'b0;
      overflow <= 1'b0;
    end else begin
      irq <= enable && (((modeE == MODE_PWM) && terminal) ||
                        ((modeE == MODE_EVT) && rise && terminal) ||
                        strobe.capP);
      if (!enable)
        overflow <= 1'b0;
      else if ((modeE == MODE_CAP) && strobe.inc && atMax)
        overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/mm_timer.sv
module mm_timer
  import mmt_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] periodIn,
  input  logic [CW-1:0] widthIn,
  input  logic          extIn,
  output logic          pwmOut,
  output logic          irq,
  output logic          overflow,
  output logic [CW-1:0] countOut,
  output logic [CW-1:0] capWidth,
  output logic [CW-1:0] capPeriod
);
  ctrlStrobe_t strobe;
  logic extRise, extFall;
  logic terminal, atMax, belowWidth, pwmEn;

  mmt_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .din(extIn), .rise(extRise), .fall(extFall)
  );

  mmt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
    .rise(extRise), .fall(extFall), .terminal(terminal), .atMax(atMax),
    .strobe(strobe), .pwmEn(pwmEn), .irq(irq), .overflow(overflow)
  );

  mmt_datapath #(.CW(CW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .periodIn(periodIn), .widthIn(widthIn),
    .count(countOut), .capWidth(capWidth), .capPeriod(capPeriod),
    .terminal(terminal), .atMax(atMax), .belowWidth(belowWidth)
  );

  assign pwmOut = pwmEn && belowWidth;
endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          enable,
  input logic [1:0]    mode,
  input logic [CW-1:0] periodIn,
  input logic [CW-1:0] widthIn,
  input logic          pwmOut,
  input logic          irq,
  input logic          overflow,
  input logic [CW-1:0] countOut,
  input logic [CW-1:0] capPeriod
);
  assert_pwm_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    pwmOut |-> (enable && mode == 2'b00));

  assert_pwm_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && mode == 2'b00 && widthIn == '0) |-> !pwmOut);

  assert_pwm_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && mode == 2'b00 && periodIn != '0 && widthIn >= periodIn &&
     countOut < periodIn) |-> pwmOut);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (countOut == '0 && !irq && !overflow));

  assert_cap_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capPeriod) |-> irq);

  assert_ovf_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> ($past(mode) == 2'b10 && $past(enable)));

  assert_evt_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irq && enable && mode == 2'b01 && $past(mode) == 2'b01 && $past(enable))
      |-> countOut == '0);
endmodule

bind mm_timer mm_timer_chk #(.CW(CW)) chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
  .periodIn(periodIn), .widthIn(widthIn), .pwmOut(pwmOut), .irq(irq),
  .overflow(overflow), .countOut(countOut), .capPeriod(capPeriod)
);

// File: tb/mm_timer_tb_top.sv
module mm_timer_tb_top;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [CW-1:0] periodIn = '0;
  logic [CW-1:0] widthIn = '0;
  logic          extIn = 1'b0;
  logic          pwmOut, irq, overflow;
  logic [CW-1:0] countOut, capWidth, capPeriod;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    string req;
    bit    isCap;
    int    expCount;
    int    expW;
    int    expP;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  mm_timer #(.CW(CW)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
    .periodIn(periodIn), .widthIn(widthIn), .extIn(extIn),
    .pwmOut(pwmOut), .irq(irq), .overflow(overflow),
    .countOut(countOut), .capWidth(capWidth), .capPeriod(capPeriod)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pushCount(string req, int c);
    item_t it;
    it.req = req; it.isCap = 1'b0; it.expCount = c; it.expW = 0; it.expP = 0;
    sb.push_back(it);
  endtask

  task automatic pushCap(string req, int w, int p);
    item_t it;
    it.req = req; it.isCap = 1'b1; it.expCount = 0; it.expW = w; it.expP = p;
    sb.push_back(it);
  endtask

  task automatic pulse(int hi, int lo);
    extIn = 1'b1;
    repeat (hi) @(negedge clk);
    extIn = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic pwmRun(string req, int per, int wid, int cycles, int fullPer);
    @(negedge clk);
    mode = 2'b00; periodIn = CW'(per); widthIn = CW'(wid); enable = 1'b1;
    for (int j = 0; j < cycles; j++) begin
      #1;
      chk(req, int'(pwmOut), ((j % fullPer) < wid) ? 1 : 0);
      @(negedge clk);
    end
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // monitor: every irq must match the next expected item
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rstN && irq) begin
        if (sb.size() == 0) begin
          chk("R5/R6/R8 unexpected irq", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          if (it.isCap) begin
            chk({it.req, " capWidth"}, int'(capWidth), it.expW);
            chk({it.req, " capPeriod"}, int'(capPeriod), it.expP);
          end else begin
            chk({it.req, " count at irq"}, int'(countOut), it.expCount);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk("R1 count", int'(countOut), 0);
    chk("R1 pwmOut", int'(pwmOut), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 capWidth", int'(capWidth), 0);
    chk("R1 capPeriod", int'(capPeriod), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3/R5: basic PWM, irq at cycles 10, 20, 30
    pushCount("R5 pwm period", 0);
    pushCount("R5 pwm period", 0);
    pushCount("R5 pwm period", 0);
    pwmRun("R3 pwm 3/10", 10, 3, 30, 10);
    #1;
    chk("R2 count cleared", int'(countOut), 0);

    // R4: zero width and oversize width
    pushCount("R5 pwm zero width", 0);
    pushCount("R5 pwm zero width", 0);
    pwmRun("R4 width zero", 5, 0, 12, 5);
    pushCount("R5 pwm full width", 0);
    pushCount("R5 pwm full width", 0);
    pwmRun("R4 width over period", 5, 7, 12, 5);

    // R3: period 0 means 2^CW
    pushCount("R3 period zero wrap", 0);
    pwmRun("R3 period zero", 0, 200, 257, 256);

    // R6: event counting
    @(negedge clk);
    mode = 2'b01; periodIn = CW'(4); enable = 1'b1;
    repeat (2) @(negedge clk);
    pulse(2, 2); pulse(2, 2); pulse(3, 1);
    repeat (4) @(negedge clk);
    #1;
    chk("R6 three events", int'(countOut), 3);
    chk("R10 pwm low in event mode", int'(pwmOut), 0);
    pushCount("R6 event wrap", 0);
    pulse(2, 2);
    repeat (4) @(negedge clk);
    #1;
    chk("R6 wrapped count", int'(countOut), 0);
    pulse(1, 3); pulse(2, 2);
    repeat (4) @(negedge clk);
    #1;
    chk("R6 after wrap", int'(countOut), 2);
    enable = 1'b0;
    repeat (3) @(negedge clk);

    // R7/R8: capture of uneven pulses
    mode = 2'b10; enable = 1'b1;
    repeat (3) @(negedge clk);
    pushCap("R8 capture 1", 5, 12);
    pushCap("R8 capture 2", 3, 12);
    pushCap("R8 capture 3", 10, 14);
    pulse(5, 7);
    pulse(3, 9);
    pulse(10, 4);
    pulse(2, 6);
    #1;
    chk("R7 last width", int'(capWidth), 2);
    chk("R8 period held", int'(capPeriod), 14);
    chk("R10 pwm low in capture", int'(pwmOut), 0);
    enable = 1'b0;
    repeat (3) @(negedge clk);

    // R9: overflow on a long high pulse
    enable = 1'b1;
    repeat (3) @(negedge clk);
    extIn = 1'b1;
    repeat (250) @(negedge clk);
    #1;
    chk("R9 no overflow yet", int'(overflow), 0);
    repeat (50) @(negedge clk);
    #1;
    chk("R9 overflow set", int'(overflow), 1);
    extIn = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    chk("R9 overflow sticky", int'(overflow), 1);
    enable = 1'b0;
    @(negedge clk);
    #1;
    chk("R2 overflow cleared", int'(overflow), 0);
    chk("R2 count cleared", int'(countOut), 0);

    // R2: reserved mode stays idle
    mode = 2'b11; enable = 1'b1; widthIn = CW'(50);
    repeat (2) @(negedge clk);
    pulse(2, 2); pulse(2, 2);
    #1;
    chk("R2 reserved count", int'(countOut), 0);
    chk("R2 reserved pwm", int'(pwmOut), 0);
    chk("R2 reserved irq", int'(irq), 0);
    enable = 1'b0;
    repeat (4) @(negedge clk);

    chk("R5/R6/R8 all expected irqs seen", sb.size(), 0);
    finished = 1'b1;
    summary();
  end
endmodule